// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave

This block is a two-wire serial-bus slave that only accepts writes. A local system clock oversamples the bus clock and data lines. The block finds the begin and end conditions and compares the first byte of a transfer with a fixed write address. Each data byte that follows goes into the next entry of a small bank of control registers. The bank is exposed as parallel outputs, and a clock-generation block uses them to enable or disable its individual clock outputs.

There is no register-pointer byte and no read path. Every accepted transfer fills the bank from entry 0 upward. To change a later entry, the master sends again every byte before it. The bank holds up to ten bytes by default. The data line is open drain: the block only ever pulls it low, to acknowledge a byte.

Top module: `cfg_i2c_wslave`

## Requirements
- R1: After reset every register entry reads 0xFF, so all controlled outputs are enabled, and `sda_pull` is 0.
- R2: A falling data line while the bus clock is high starts a transfer. A rising data line while the bus clock is high ends it. After the end condition `sda_pull` is 0 on the next cycle.
- R3: If the first byte after a start is 0xD2, the block acknowledges it. It does this by pulling the data line low (`sda_pull` = 1) for the whole ninth bus-clock period, from the falling bus clock after bit 8 until the next falling bus clock.
- R4: For any other first byte (including 0xD3, a read), the block does not acknowledge. It leaves every register unchanged and ignores all further bytes until the next start condition.
- R5: Data bytes are received most significant bit first, with each bit sampled while the bus clock is high. Data byte k of an accepted transfer is stored in entry k, which appears on `ctrl_o[8k+7:8k]`. Entries that the transfer does not reach keep their previous values.
- R6: Each data byte stored in an entry is acknowledged in the same way as the address byte.
- R7: Only the first NREG (default 10) data bytes of a transfer are stored. Later bytes are not acknowledged, and no entry changes.
- R8: A repeated start without a stop condition resets the byte index, so the next accepted data byte goes to entry 0.
- R9: A register changes only when its byte is committed, at the falling bus clock that begins the acknowledge. `sda_pull` changes only after a falling bus clock or after a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Data line as received (wired-AND level) |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge), 0 releases it |
| ctrl_o | output | 8*NREG | Register bank, entry k at bits 8k+7:8k |

## Verification
The main function is driven through a table of transfers that differ in address and length. A short write to 0xD2 shows that bytes land in order from entry 0 and that the entries it does not reach are left alone. The read address 0xD3 and an unrelated address show that both the acknowledge and the storage are gated on the exact write address. A twelve-byte write finds the boundary between the tenth byte, which is acknowledged, and the eleventh, which is not. A separate repeated-start sequence tells index reset apart from index continuation.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_WAIT_ACK,
    ST_ACK,
    ST_IGNORE
  } wsl_state_e;

  // Address byte match: 7-bit device address with write (0) in LSB
  function automatic logic addr_hit(input logic [7:0] rx_byte, input logic [6:0] dev7);
    return rx_byte == {dev7, 1'b0};
  endfunction

  // True while the bank still has a free entry at index idx
  function automatic logic slot_free(input int unsigned idx, input int unsigned depth);
    return idx < depth;
  endfunction

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_bit
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_bit  = sda_s;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int         NREG      = 10,
  parameter logic [6:0] DEV_ADDR7 = 7'h69,
  localparam int        IW        = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_bit,
  output logic          sda_pull,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data
);

  wsl_state_e    state;
  logic [2:0]    bitcnt;
  logic [7:0]    shreg;
  logic          is_addr;
  logic [IW-1:0] idx;
  logic          take_data;

  assign take_data = !is_addr && slot_free(32'(idx), NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      is_addr <= 1'b0;
      idx     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state   <= ST_RECV;
        bitcnt  <= '0;
        is_addr <= 1'b1;
        idx     <= '0;
      end else if (stop_ev) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RECV: if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_bit};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= ST_WAIT_ACK;
          end
          ST_WAIT_ACK: if (scl_fall) begin
            if (is_addr) begin
              is_addr <= 1'b0;
              state   <= addr_hit(shreg, DEV_ADDR7) ? ST_ACK : ST_IGNORE;
            end else if (take_data) begin
              state   <= ST_ACK;
              wr_en   <= 1'b1;
              wr_idx  <= idx;
              wr_data <= shreg;
              idx     <= idx + 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ACK: if (scl_fall) begin
            state  <= ST_RECV;
            bitcnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = (state == ST_ACK);

  // R9
  ack_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R2
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull);

  // R8
  index_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (idx == '0));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int  NREG = 10,
  localparam int IW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  output logic [8*NREG-1:0] bank_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic [7:0] entry_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                entry_q <= 8'hFF;
      else if (wr_en && wr_idx == IW'(g))        entry_q <= wr_data;
    end
    assign bank_o[8*g +: 8] = entry_q;
  end

  // R7
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NREG));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_o));

endmodule

// File: rtl/cfg_i2c_wslave.sv
module cfg_i2c_wslave #(
  parameter int         NREG        = 10,
  parameter logic [6:0] DEV_ADDR7   = 7'h69,
  parameter int         SYNC_STAGES = 2,
  localparam int        IW          = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic [8*NREG-1:0] ctrl_o
);

  logic          scl_rise, scl_fall, start_ev, stop_ev, sda_bit;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_bit  (sda_bit)
  );

  i2c_wr_fsm #(.NREG(NREG), .DEV_ADDR7(DEV_ADDR7)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_bit  (sda_bit),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  cfg_reg_bank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .bank_o  (ctrl_o)
  );

  // R9
  pull_change_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_ev || stop_ev));

  // R6
  commit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_pull);

endmodule

// File: tb/tb_cfg_i2c_wslave.sv
module tb_cfg_i2c_wslave;

  localparam int NREG = 10;
  localparam int H    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [8*NREG-1:0] ctrl_o;

  assign sda_line = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  cfg_i2c_wslave #(.NREG(NREG)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_pull (sda_pull),
    .ctrl_o   (ctrl_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [NREG];

  localparam int NV = 4;
  localparam logic [7:0] V_ADDR [NV] = '{8'hD2, 8'hD3, 8'hA4, 8'hD2};
  localparam int         V_CNT  [NV] = '{3, 2, 1, 12};
  localparam logic [7:0] V_SEED [NV] = '{8'h11, 8'h55, 8'h3C, 8'h80};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H);
      scl_m = 1'b1; wt(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    acked = ~sda_line;
    scl_m = 1'b0; wt(H);
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NREG; k++)
      chk(req, {24'h0, ctrl_o[8*k +: 8]}, {24'h0, model[k]});
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int k = 0; k < NREG; k++) model[k] = 8'hFF;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk("R1 bank", {31'h0, &ctrl_o}, 32'h1);
    chk("R1 pull", {31'h0, sda_pull}, 32'h0);

    // Table-driven transfers: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      bus_start();
      send_byte(V_ADDR[v], ack);
      chk(V_ADDR[v] == 8'hD2 ? "R3 addr ack" : "R4 addr nack",
          {31'h0, ack}, {31'h0, V_ADDR[v] == 8'hD2});
      for (int k = 0; k < V_CNT[v]; k++) begin
        d = V_SEED[v] + 8'(k * 29);
        send_byte(d, ack);
        if (V_ADDR[v] == 8'hD2 && k < NREG) begin
          chk("R6 data ack", {31'h0, ack}, 32'h1);
          model[k] = d;
        end else begin
          chk(V_ADDR[v] == 8'hD2 ? "R7 overflow nack" : "R4 ignored byte",
              {31'h0, ack}, 32'h0);
        end
      end
      bus_stop();
      wt(5);
      // R2 released after stop
      chk("R2 released", {31'h0, sda_pull}, 32'h0);
      check_bank(v == 3 ? "R7 bank" : (V_ADDR[v] == 8'hD2 ? "R5 bank" : "R4 bank"));
    end

    // R8 repeated start restarts at entry 0
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hA1, ack); model[0] = 8'hA1;
    send_byte(8'hB2, ack); model[1] = 8'hB2;
    bus_start();
    send_byte(8'hD2, ack);
    chk("R8 addr ack", {31'h0, ack}, 32'h1);
    send_byte(8'h5E, ack); model[0] = 8'h5E;
    bus_stop();
    wt(5);
    check_bank("R8 bank");

    // R1 reset again restores all ones
    rst_n = 1'b0; wt(3); rst_n = 1'b1; wt(3);
    chk("R1 reset again", {31'h0, &ctrl_o}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule